// File: doc/BRIEF.md
# Full-Map Coherence Directory Controller

This block is the central directory for a small shared-memory system with a fixed number of private caches. For every memory block it keeps one presence flag per cache and one sole-writer flag. The sole-writer flag means that exactly one cache holds the block with permission to write. Caches send three kinds of request: a read miss, a write miss, and an upgrade, which asks for write permission on a line the cache already holds shared.

The controller handles one transaction at a time. It accepts a request, reads the entry, and if needed sends one command pulse to the caches that must act. The command tells them to invalidate, to forward the line to the requester, or to invalidate and return the data to memory. It then waits for an acknowledgement from each targeted cache. After that it updates the entry and returns a grant to the requester. The grant carries the new presence vector and sole-writer flag, and it carries memory data when memory is the source.

A cache that already holds a line privately writes it locally and sends nothing. Memory is a small internal word array. Each word resets to the bitwise inverse of its entry index.

Top module: `coh_dir_ctrl`

## Requirements
- R1: Request codes are 0 for read miss, 1 for write miss and 2 for upgrade. In an idle cycle the lowest-indexed cache with a valid request sees ready, and only that cache sees it. While a transaction is in progress no ready is given, so other requests stall until the controller is idle again.
- R2: A read miss to an entry with no other holder gets a grant of kind 0 (shared) in the cycle after acceptance. The grant has the memory flag set, carries the stored word, reports the requester as the only holder and reports sole-writer clear.
- R3: A read miss to an entry with sole-writer clear and other holders sends a forward command (code 1) to the lowest-indexed other holder, with the destination set to the requester. After that holder acknowledges, the requester gets a shared grant without memory data. Presence becomes the old holders plus the requester, and sole-writer stays clear.
- R4: A read miss to an entry with sole-writer set sends a forward command to the owner. The grant then reports the owner and the requester as holders and reports sole-writer cleared.
- R5: A write miss or upgrade sends an invalidate command (code 0) to every other holder, all in the same single cycle. The grant is withheld until every targeted cache has acknowledged. An acknowledgement from a cache that was not targeted has no effect.
- R6: A write miss to an entry owned by another cache (sole-writer set) sends a flush command (code 2) to that owner. The data on the owner's acknowledgement is written to memory. The grant is of kind 1 (exclusive), has the memory flag set and carries that data. Data on acknowledgements from caches that were not targeted is not stored.
- R7: After a write miss or an upgrade, the grant reports the requester as the only holder and reports sole-writer set.
- R8: An upgrade is granted with kind 2 (private acknowledge) and no memory data. When no other cache holds the line, it is granted in the cycle after acceptance and no command is sent.
- R9: A command is a one-cycle pulse in the cycle after acceptance. When acknowledgements are needed, the grant appears two cycles after the cycle in which the last awaited acknowledgement is presented. A grant is a one-cycle pulse on the requester's lane.
- R10: After reset every entry has no holders and sole-writer clear, and no command or grant is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N | Request valid, one per cache |
| req_op | input | 2*N | Request code per cache |
| req_idx | input | N*IW | Entry index per cache |
| req_ready | output | N | Request accepted this cycle |
| cmd_valid | output | N | Command pulse, one bit per targeted cache |
| cmd_kind | output | 2 | 0 invalidate, 1 forward, 2 flush to memory |
| cmd_idx | output | IW | Entry the command refers to |
| cmd_dest | output | CW | Requester that forwarded data goes to |
| ack_valid | input | N | Acknowledgement from each cache |
| ack_data | input | N*DW | Data returned with a flush acknowledgement |
| gnt_valid | output | N | Grant pulse on the requester's lane |
| gnt_kind | output | 2 | 0 shared, 1 exclusive, 2 private acknowledge |
| gnt_mem | output | 1 | Grant data comes from memory |
| gnt_data | output | DW | Memory word (zero when gnt_mem is clear) |
| gnt_presence | output | N | Presence vector after the transaction |
| gnt_sw | output | 1 | Sole-writer flag after the transaction |

## Verification
A behavioural model in the bench tracks presence, sole-writer and memory for each entry. Every cycle of each transaction is compared with that model: command lanes, kind and destination, the exact grant cycle and all grant fields. Read misses are tried on an empty entry, a shared entry and an owned entry, which separates memory supply, forwarding from the lowest sharer and the owner demotion. Write misses and upgrades are tried with several sharers that acknowledge on different cycles, which shows that the grant waits for the last acknowledgement. They are also tried against an owner with stray acknowledgements carrying garbage data, which separates flush write-back from false acknowledgements, and against no other holder, which shows the zero-wait path. A held request from a higher-indexed cache during a transaction checks both priority and stalling.

// File: rtl/coh_pkg.sv
// Shared encodings for the directory controller.
// Assumes two-bit request, command and grant codes on the ports.
package coh_pkg;
    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_UPG = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        CMD_INV   = 2'd0,
        CMD_FWD   = 2'd1,
        CMD_FLUSH = 2'd2
    } cmd_e;

    typedef enum logic [1:0] {
        G_SHARED = 2'd0,
        G_EXCL   = 2'd1,
        G_PRIV   = 2'd2
    } gnt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_GRANT = 2'd3
    } st_e;
endpackage

// File: rtl/coh_arb.sv
// Fixed-priority picker: lowest-indexed active request wins.
// Assumes N >= 2; purely combinational.
module coh_arb #(
    parameter int N  = 4,
    parameter int CW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [CW-1:0] sel
);
    // Scan upward and keep the first active lane.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        sel   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                found    = 1'b1;
                grant[i] = 1'b1;
                sel      = CW'(i);
            end
        end
    end
endmodule

// File: rtl/coh_ack_tracker.sv
// Tracks which caches still owe an acknowledgement, plus a count of them.
// Assumes load never coincides with an outstanding ack set.
module coh_ack_tracker #(
    parameter int N    = 4,
    parameter int CNTW = $clog2(N + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] load_mask,
    input  logic [N-1:0] ack,
    output logic [N-1:0] pending,
    output logic         done
);
    logic [CNTW-1:0] count_q;
    logic [N-1:0]    hit;

    // Only acknowledgements from awaited caches count.
    assign hit  = ack & pending;
    assign done = (count_q == '0);

    // Load the wait set on accept, then retire lanes as they acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            count_q <= '0;
        end else if (load) begin
            pending <= load_mask;
            count_q <= CNTW'($countones(load_mask));
        end else begin
            pending <= pending & ~hit;
            count_q <= count_q - CNTW'($countones(hit));
        end
    end

    // R5: the counter and the wait set never disagree.
    a_r5_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        count_q == CNTW'($countones(pending)));
endmodule

// File: rtl/coh_dir_store.sv
// Directory entries (presence vector, sole-writer flag) and memory words.
// One asynchronous read port, one directory write port, one memory write port.
// Memory word e resets to the bitwise inverse of e.
module coh_dir_store #(
    parameter int N  = 4,
    parameter int E  = 16,
    parameter int DW = 32,
    parameter int IW = $clog2(E)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ridx,
    output logic [N-1:0]  rpres,
    output logic          rsw,
    output logic [DW-1:0] rdata,
    input  logic          dwe,
    input  logic [IW-1:0] didx,
    input  logic [N-1:0]  dpres,
    input  logic          dsw,
    input  logic          mwe,
    input  logic [IW-1:0] midx,
    input  logic [DW-1:0] mdata
);
    logic [N-1:0]  pres_q [E];
    logic          sw_q   [E];
    logic [DW-1:0] mem_q  [E];
    logic [E-1:0]  dsel, msel;

    // Per-entry write decode.
    for (genvar e = 0; e < E; e++) begin : g_dec
        assign dsel[e] = dwe && (didx == IW'(e));
        assign msel[e] = mwe && (midx == IW'(e));
    end

    // Reset all entries; apply directory and memory writes.
    always_ff @(posedge clk) begin
        for (int e = 0; e < E; e++) begin
            if (!rst_n) begin
                pres_q[e] <= '0;
                sw_q[e]   <= 1'b0;
                mem_q[e]  <= ~DW'(e);
            end else begin
                if (dsel[e]) begin
                    pres_q[e] <= dpres;
                    sw_q[e]   <= dsw;
                end
                if (msel[e]) mem_q[e] <= mdata;
            end
        end
    end

    assign rpres = pres_q[ridx];
    assign rsw   = sw_q[ridx];
    assign rdata = mem_q[ridx];
endmodule

// File: rtl/coh_dir_ctrl.sv
// Full-map directory controller, one transaction at a time.
// Accepts read miss, write miss and upgrade requests; sends one command pulse
// to the caches that must act, waits for all their acks, then grants.
// Assumes caches take a command in the cycle it is pulsed.
module coh_dir_ctrl #(
    parameter int N  = 4,
    parameter int E  = 16,
    parameter int DW = 32,
    parameter int CW = $clog2(N),
    parameter int IW = $clog2(E)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_valid,
    input  logic [2*N-1:0]  req_op,
    input  logic [N*IW-1:0] req_idx,
    output logic [N-1:0]    req_ready,
    output logic [N-1:0]    cmd_valid,
    output logic [1:0]      cmd_kind,
    output logic [IW-1:0]   cmd_idx,
    output logic [CW-1:0]   cmd_dest,
    input  logic [N-1:0]    ack_valid,
    input  logic [N*DW-1:0] ack_data,
    output logic [N-1:0]    gnt_valid,
    output logic [1:0]      gnt_kind,
    output logic            gnt_mem,
    output logic [DW-1:0]   gnt_data,
    output logic [N-1:0]    gnt_presence,
    output logic            gnt_sw
);
    import coh_pkg::*;

    st_e           state_q;
    logic [CW-1:0] t_req;
    logic [N-1:0]  t_reqbit, t_cmask, t_pres;
    logic [IW-1:0] t_idx;
    cmd_e          t_ckind;
    gnt_e          t_gkind;
    logic          t_gmem, t_sw;

    logic [N-1:0]  arb_gnt;
    logic [CW-1:0] arb_sel;
    logic [1:0]    sel_op;
    logic [IW-1:0] sel_idx, rd_idx;
    logic [N-1:0]  rd_pres, others, low_other;
    logic          rd_sw;
    logic [DW-1:0] rd_data;
    logic          accept;

    logic [N-1:0]  d_mask, d_pres;
    cmd_e          d_ckind;
    gnt_e          d_gkind;
    logic          d_gmem, d_sw;

    logic [N-1:0]  trk_pending, flush_hit;
    logic          trk_done, mwe;
    logic [DW-1:0] mdata;

    coh_arb #(.N(N), .CW(CW)) u_arb (
        .req   (req_valid),
        .grant (arb_gnt),
        .sel   (arb_sel)
    );

    // Select the winning lane's code and index.
    always_comb begin
        sel_op  = req_op[int'(arb_sel)*2 +: 2];
        sel_idx = req_idx[int'(arb_sel)*IW +: IW];
    end

    assign accept    = (state_q == ST_IDLE) && (|req_valid);
    assign req_ready = (state_q == ST_IDLE) ? arb_gnt : '0;
    assign rd_idx    = (state_q == ST_IDLE) ? sel_idx : t_idx;

    coh_dir_store #(.N(N), .E(E), .DW(DW), .IW(IW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .ridx  (rd_idx),
        .rpres (rd_pres),
        .rsw   (rd_sw),
        .rdata (rd_data),
        .dwe   (state_q == ST_GRANT),
        .didx  (t_idx),
        .dpres (t_pres),
        .dsw   (t_sw),
        .mwe   (mwe),
        .midx  (t_idx),
        .mdata (mdata)
    );

    // Holders other than the requester, and the lowest of them.
    always_comb begin
        logic found;
        others    = rd_pres & ~arb_gnt;
        low_other = '0;
        found     = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (others[k] && !found) begin
                found        = 1'b1;
                low_other[k] = 1'b1;
            end
        end
    end

    // Decide commands, grant kind and the new entry from the request.
    always_comb begin
        case (op_e'(sel_op))
            OP_WR, OP_UPG: begin
                d_mask  = others;
                d_ckind = (rd_sw && others != '0) ? CMD_FLUSH : CMD_INV;
                d_gkind = (op_e'(sel_op) == OP_WR) ? G_EXCL : G_PRIV;
                d_gmem  = (op_e'(sel_op) == OP_WR);
                d_pres  = arb_gnt;
                d_sw    = 1'b1;
            end
            default: begin
                d_mask  = rd_sw ? others : low_other;
                d_ckind = CMD_FWD;
                d_gkind = G_SHARED;
                d_gmem  = (others == '0);
                d_pres  = rd_pres | arb_gnt;
                d_sw    = 1'b0;
            end
        endcase
    end

    coh_ack_tracker #(.N(N)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && d_mask != '0),
        .load_mask (d_mask),
        .ack       (ack_valid),
        .pending   (trk_pending),
        .done      (trk_done)
    );

    // Capture the flushing owner's data for the memory write.
    always_comb begin
        flush_hit = ack_valid & trk_pending;
        mdata     = '0;
        for (int k = 0; k < N; k++) begin
            if (flush_hit[k]) mdata = mdata | ack_data[k*DW +: DW];
        end
    end
    assign mwe = (state_q == ST_SEND || state_q == ST_WAIT) &&
                 (t_ckind == CMD_FLUSH) && (flush_hit != '0);

    // Transaction sequencing and capture of the decision on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            t_req    <= '0;
            t_reqbit <= '0;
            t_idx    <= '0;
            t_cmask  <= '0;
            t_ckind  <= CMD_INV;
            t_gkind  <= G_SHARED;
            t_gmem   <= 1'b0;
            t_pres   <= '0;
            t_sw     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    t_req    <= arb_sel;
                    t_reqbit <= arb_gnt;
                    t_idx    <= sel_idx;
                    t_cmask  <= d_mask;
                    t_ckind  <= d_ckind;
                    t_gkind  <= d_gkind;
                    t_gmem   <= d_gmem;
                    t_pres   <= d_pres;
                    t_sw     <= d_sw;
                    state_q  <= (d_mask != '0) ? ST_SEND : ST_GRANT;
                end
                ST_SEND:  state_q <= ST_WAIT;
                ST_WAIT:  if (trk_done) state_q <= ST_GRANT;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_valid    = (state_q == ST_SEND) ? t_cmask : '0;
    assign cmd_kind     = t_ckind;
    assign cmd_idx      = t_idx;
    assign cmd_dest     = t_req;
    assign gnt_valid    = (state_q == ST_GRANT) ? t_reqbit : '0;
    assign gnt_kind     = t_gkind;
    assign gnt_mem      = t_gmem;
    assign gnt_data     = (state_q == ST_GRANT && t_gmem) ? rd_data : '0;
    assign gnt_presence = (state_q == ST_GRANT) ? t_pres : '0;
    assign gnt_sw       = (state_q == ST_GRANT) && t_sw;

    // R1: at most one cache is accepted per cycle.
    a_r1_ready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));
    // R1: an accepted request always produces a command or a grant next.
    a_r1_accept_acts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid != '0) |=> (cmd_valid != '0 || gnt_valid != '0));
    // R5: no grant while any awaited acknowledgement is missing.
    a_r5_grant_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid != '0) |-> (trk_pending == '0));
    // R7: a write or upgrade grant leaves the requester as sole holder.
    a_r7_write_sole: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid != '0 && gnt_kind != 2'(G_SHARED)) |-> (gnt_sw && gnt_presence == gnt_valid));
    // R3: a shared grant keeps sole-writer clear and includes the requester.
    a_r3_read_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid != '0 && gnt_kind == 2'(G_SHARED)) |-> (!gnt_sw && (gnt_presence & gnt_valid) != '0));
    // R9: commands are single-cycle pulses.
    a_r9_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid != '0) |=> (cmd_valid == '0));
    // R9: grants are single-cycle pulses on one lane.
    a_r9_gnt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid != '0) |=> (gnt_valid == '0 && $onehot0($past(gnt_valid))));
endmodule

// File: tb/sim_coh_dir_ctrl.sv
// Bench: behavioural directory model compared every cycle of each transaction.
module sim_coh_dir_ctrl;
    localparam int N  = 4;
    localparam int E  = 16;
    localparam int DW = 32;
    localparam int CW = 2;
    localparam int IW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [2*N-1:0]  req_op = '0;
    logic [N*IW-1:0] req_idx = '0;
    logic [N-1:0]    req_ready, cmd_valid, ack_valid = '0, gnt_valid, gnt_presence;
    logic [1:0]      cmd_kind, gnt_kind;
    logic [IW-1:0]   cmd_idx;
    logic [CW-1:0]   cmd_dest;
    logic [N*DW-1:0] ack_data = '0;
    logic            gnt_mem, gnt_sw;
    logic [DW-1:0]   gnt_data;

    int n_chk = 0, n_fail = 0, cyc = 0;

    logic [N-1:0]  m_pres [E];
    bit            m_sw   [E];
    logic [DW-1:0] m_mem  [E];

    always #2 clk = ~clk;

    coh_dir_ctrl #(.N(N), .E(E), .DW(DW)) u0 (.*);

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic set_lane(int c, bit v, int op, int idx);
        req_valid[c]           = v;
        req_op[c*2 +: 2]       = 2'(op);
        req_idx[c*IW +: IW]    = IW'(idx);
    endtask

    function automatic logic [DW-1:0] flushval(int idx, int k);
        return 32'hF000_0000 | DW'(idx << 8) | DW'(k);
    endfunction

    // One transaction from cache c; 'other' >= 0 names a lane that must stall.
    task automatic do_txn(int c, int op, int idx, int other = -1);
        logic [N-1:0] rb, oth, tgt, npres;
        int ck, gk, gm, last, g, wt, owner;
        bit nsw;
        string tag;
        logic [DW-1:0] edata;
        rb  = N'(1) << c;
        oth = m_pres[idx] & ~rb;
        owner = 0;
        for (int k = N - 1; k >= 0; k--) if (oth[k]) owner = k;
        if (op == 0) begin
            tgt = (oth == '0) ? '0 : (m_sw[idx] ? oth : (N'(1) << owner));
            ck = 1; gk = 0; gm = (oth == '0);
            npres = m_pres[idx] | rb; nsw = 0;
            tag = (oth == '0) ? "R2" : (m_sw[idx] ? "R4" : "R3");
        end else begin
            tgt = oth;
            ck = (m_sw[idx] && oth != '0) ? 2 : 0;
            gk = (op == 1) ? 1 : 2; gm = (op == 1);
            npres = rb; nsw = 1;
            tag = (op == 1) ? ((ck == 2) ? "R6" : "R7") : "R8";
        end
        if (ck == 2) m_mem[idx] = flushval(idx, owner);
        edata = gm ? m_mem[idx] : '0;
        last = 0;
        for (int k = 0; k < N; k++) if (tgt[k] && 1 + (k + idx) % 3 > last) last = 1 + (k + idx) % 3;
        g = (tgt == '0) ? 1 : last + 2;

        @(negedge clk);
        set_lane(c, 1'b1, op, idx);
        #1;
        wt = 0;
        while (!req_ready[c] && wt < 60) begin
            @(negedge clk); #1; wt++;
        end
        chk(req_ready == rb, "R1", "ready lane on accept", req_ready, rb);

        for (int n = 1; n <= g; n++) begin
            @(negedge clk);
            ack_valid = '0;
            ack_data  = '0;
            if (n == 1) req_valid[c] = 1'b0;
            // Command expected only in the first cycle after acceptance (R9).
            chk(cmd_valid == ((n == 1) ? tgt : '0), "R9", "cmd lanes", cmd_valid, (n == 1) ? tgt : '0);
            if (n == 1 && tgt != '0) begin
                chk(cmd_kind == 2'(ck), (ck == 0) ? "R5" : tag, "cmd kind", cmd_kind, ck);
                chk(cmd_idx == IW'(idx), tag, "cmd idx", cmd_idx, idx);
                if (ck == 1) chk(cmd_dest == CW'(c), "R3", "cmd dest", cmd_dest, c);
            end
            if (n == g) begin
                chk(gnt_valid == rb, "R9", "grant lane/cycle", gnt_valid, rb);
                chk(gnt_kind == 2'(gk), tag, "grant kind", gnt_kind, gk);
                chk(gnt_mem == gm[0], tag, "grant mem flag", gnt_mem, gm);
                chk(gnt_data == edata, tag, "grant data", gnt_data, edata);
                chk(gnt_presence == npres, tag, "presence", gnt_presence, npres);
                chk(gnt_sw == nsw, tag, "sole-writer", gnt_sw, nsw);
            end else begin
                chk(gnt_valid == '0, "R5", "early grant", gnt_valid, 0);
            end
            if (other >= 0) chk(req_ready[other] == 1'b0, "R1", "stalled lane ready", req_ready[other], 0);
            for (int k = 0; k < N; k++) begin
                if (tgt[k] && n == 1 + (k + idx) % 3) begin
                    ack_valid[k] = 1'b1;
                    ack_data[k*DW +: DW] = (ck == 2) ? flushval(idx, k) : '0;
                end
                // Stray acks with garbage data from non-targets (R5, R6).
                if (tgt != '0 && n == 1 && !tgt[k] && k != c && k != other) begin
                    ack_valid[k] = 1'b1;
                    ack_data[k*DW +: DW] = 32'hBAD0_0000 | DW'(k);
                end
            end
        end
        m_pres[idx] = npres;
        m_sw[idx]   = nsw;
        @(negedge clk);
        ack_valid = '0;
        ack_data  = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < E; i++) begin
            m_pres[i] = '0;
            m_sw[i]   = 0;
            m_mem[i]  = ~DW'(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_valid == '0, "R10", "cmd after reset", cmd_valid, 0);
        chk(gnt_valid == '0, "R10", "grant after reset", gnt_valid, 0);
        chk(req_ready == '0, "R10", "ready with no request", req_ready, 0);

        do_txn(0, 0, 3);        // R2/R10: empty entry read from memory
        do_txn(2, 0, 3);        // R3: forward from sharer 0
        do_txn(1, 0, 3);        // R3: lowest other sharer forwards
        do_txn(3, 1, 3);        // R5/R7: three invalidates, staggered acks
        do_txn(0, 0, 3);        // R4: owner demoted
        do_txn(0, 2, 3);        // R8: upgrade invalidates cache 3
        do_txn(2, 1, 3);        // R6: flush from owner 0, stray acks ignored
        do_txn(2, 2, 3);        // R8: sole owner upgrade, no commands
        do_txn(1, 1, 5);        // R7: write miss on empty entry

        set_lane(3, 1'b1, 0, 7); // R1: held request on a higher lane stalls
        do_txn(0, 0, 5, 3);
        do_txn(3, 0, 7);
        do_txn(1, 2, 5);        // R8: upgrade with one shared peer
        do_txn(0, 1, 0);
        do_txn(3, 0, 15);
        do_txn(2, 1, 15);
        do_txn(1, 0, 15);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule